// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token latches that two independent ports share in order to claim exclusive use of a common resource. Each port has its own semaphore select, read/write strobe, output enable, address and data lines. A port picks one latch with the low bits of its address and writes bit 0 of its data bus to ask for the token (0) or hand it back (1). A later read of the same latch tells the port whether it now holds the token.

Every latch runs a small state machine with three states: `SEM_FREE`, `SEM_LEFT` (the left port owns the token) and `SEM_RIGHT` (the right port owns it). A pending flag per side records a request that arrived while the other side held the token. The transitions are `GRANT_L` and `GRANT_R` (free to owned on a request, with the left port winning a tie), `PASS_L2R` and `PASS_R2L` (the owner releases while the other side is pending or requesting, so the token moves straight across), `DROP_L` and `DROP_R` (the owner releases with nobody waiting, back to free), and `HOLD` (any other case, where the state stays put and a pending flag may be set). The bank is separate from any memory array and reacts only while a port's semaphore select is high.

Top module: `sem_bank`

## Requirements
- R1: The bank has eight latches. The latch is chosen by address bits 2..0. All higher address bits are ignored.
- R2: A write (select=1, wr=1) with data bit 0 equal to 0 is a request. A request to a free latch makes that port the owner at the next rising clock edge.
- R3: At most one port owns a latch at any time. A request to a latch owned by the other port leaves ownership unchanged and marks the requester pending.
- R4: When the owner releases a latch while the other port is pending, or is requesting in the same cycle, ownership passes to that port at the same edge and its pending mark clears.
- R5: When both ports request the same free latch in the same cycle, the left port becomes owner and the right port is marked pending.
- R6: A write with data bit 0 equal to 1 from the owner, with nobody waiting, returns the latch to free.
- R7: A release from a port that does not own the latch has no effect. This holds even when that port is pending.
- R8: A read (select=1, wr=0, oe=1) drives all data bits to 0 in the same cycle if the reading port owns the addressed latch, and drives all bits to 1 otherwise. When a port is not reading, its read data is all ones.
- R9: After reset every latch is free and no port is pending.
- R10: Writes with select=0 are ignored. A request from the port that already owns the latch has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 14 | Left address; bits 2..0 pick the latch |
| l_wdata | input | 16 | Left write data; bit 0 is the token command |
| l_rdata | output | 16 | Left read data |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 14 | Right address; bits 2..0 pick the latch |
| r_wdata | input | 16 | Right write data; bit 0 is the token command |
| r_rdata | output | 16 | Right read data |

## Verification
A write takes effect at the first rising edge that samples it. Read data depends combinationally on the latch state and on the read strobes, so a read in the cycle after a write already shows the new owner. The bench drives every input just after a falling edge, compares the read data one time step later (still before the next rising edge), and only then advances its own model by one edge. Each comparison therefore matches the state the design holds in that same cycle. Ties, pending hand-overs, non-owner releases and unselected writes are driven as directed cases and then read back through both ports.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        SEM_FREE  = 2'd0,
        SEM_LEFT  = 2'd1,
        SEM_RIGHT = 2'd2
    } sem_state_e;

    typedef enum logic [2:0] {
        TR_HOLD     = 3'd0,
        TR_GRANT_L  = 3'd1,
        TR_GRANT_R  = 3'd2,
        TR_PASS_L2R = 3'd3,
        TR_PASS_R2L = 3'd4,
        TR_DROP_L   = 3'd5,
        TR_DROP_R   = 3'd6
    } sem_trans_e;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              sel,
    input  logic              wr,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel,
    output logic              rd,
    output logic [IDX_W-1:0]  idx
);

    logic is_wr;
    logic unused_bits;

    assign idx         = addr[IDX_W-1:0];
    assign is_wr       = sel && wr;
    assign rd          = sel && !wr && oe;
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    // one-hot strobes per latch
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
        assign req[i] = is_wr && !wdata[0] && (idx == IDX_W'(i));
        assign rel[i] = is_wr &&  wdata[0] && (idx == IDX_W'(i));
    end

endmodule

// File: rtl/sem_latch.sv
module sem_latch
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);

    sem_state_e state_q, state_d;
    sem_trans_e trans;
    logic       pl_q, pl_d;
    logic       pr_q, pr_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEM_FREE;
            pl_q    <= 1'b0;
            pr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pl_q    <= pl_d;
            pr_q    <= pr_d;
        end
    end

    // transition selection
    always_comb begin
        trans = TR_HOLD;
        unique case (state_q)
            SEM_FREE: begin
                if (req_l)      trans = TR_GRANT_L;
                else if (req_r) trans = TR_GRANT_R;
            end
            SEM_LEFT: begin
                if (rel_l) trans = (pr_q || req_r) ? TR_PASS_L2R : TR_DROP_L;
            end
            SEM_RIGHT: begin
                if (rel_r) trans = (pl_q || req_l) ? TR_PASS_R2L : TR_DROP_R;
            end
            default: trans = TR_HOLD;
        endcase
    end

    // next state and pending flags
    always_comb begin
        state_d = state_q;
        pl_d    = pl_q;
        pr_d    = pr_q;
        unique case (trans)
            TR_GRANT_L: begin
                state_d = SEM_LEFT;
                pr_d    = req_r;
            end
            TR_GRANT_R:  state_d = SEM_RIGHT;
            TR_PASS_L2R: begin
                state_d = SEM_RIGHT;
                pr_d    = 1'b0;
            end
            TR_PASS_R2L: begin
                state_d = SEM_LEFT;
                pl_d    = 1'b0;
            end
            TR_DROP_L:   state_d = SEM_FREE;
            TR_DROP_R:   state_d = SEM_FREE;
            TR_HOLD: begin
                if (state_q == SEM_LEFT  && req_r) pr_d = 1'b1;
                if (state_q == SEM_RIGHT && req_l) pl_d = 1'b1;
            end
            default: state_d = state_q;
        endcase
    end

    // outputs
    always_comb begin
        own_l  = 1'b0;
        own_r  = 1'b0;
        unique case (state_q)
            SEM_LEFT:  own_l = 1'b1;
            SEM_RIGHT: own_r = 1'b1;
            default: begin
                own_l = 1'b0;
                own_r = 1'b0;
            end
        endcase
        pend_l = pl_q;
        pend_r = pr_q;
    end

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               rd,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] own,
    output logic [DATA_W-1:0]  rdata
);

    always_comb begin
        if (rd && own[idx]) rdata = '0;
        else                rdata = '1;
    end

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int IDX_W = $clog2(NUM_SEM);

    logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r;
    logic [NUM_SEM-1:0] own_l, own_r, pend_l, pend_r;
    logic               rd_l, rd_r;
    logic [IDX_W-1:0]   idx_l, idx_r;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sel(l_sel), .wr(l_wr), .oe(l_oe), .addr(l_addr), .wdata(l_wdata),
        .req(req_l), .rel(rel_l), .rd(rd_l), .idx(idx_l)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sel(r_sel), .wr(r_wr), .oe(r_oe), .addr(r_addr), .wdata(r_wdata),
        .req(req_r), .rel(rel_r), .rd(rd_r), .idx(idx_r)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
        sem_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .req_l (req_l[i]),
            .rel_l (rel_l[i]),
            .req_r (req_r[i]),
            .rel_r (rel_r[i]),
            .own_l (own_l[i]),
            .own_r (own_r[i]),
            .pend_l(pend_l[i]),
            .pend_r(pend_r[i])
        );
    end

    sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .rd(rd_l), .idx(idx_l), .own(own_l), .rdata(l_rdata)
    );

    sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .rd(rd_r), .idx(idx_r), .own(own_r), .rdata(r_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel,
    input logic               l_wr,
    input logic               l_oe,
    input logic [ADDR_W-1:0]  l_addr,
    input logic [DATA_W-1:0]  l_wdata,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sel,
    input logic               r_wr,
    input logic [ADDR_W-1:0]  r_addr,
    input logic [DATA_W-1:0]  r_wdata,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r,
    input logic [NUM_SEM-1:0] pend_r
);

    // exclusive ownership, R3
    assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    // read value follows ownership, R8
    assert_read_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_wr && l_oe) |->
        l_rdata == (own_l[l_addr[IDX_W-1:0]] ? {DATA_W{1'b0}} : {DATA_W{1'b1}}));

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_chk
        logic lq, rq, lr, rr;
        assign lq = l_sel && l_wr && !l_wdata[0] && (l_addr[IDX_W-1:0] == IDX_W'(i));
        assign lr = l_sel && l_wr &&  l_wdata[0] && (l_addr[IDX_W-1:0] == IDX_W'(i));
        assign rq = r_sel && r_wr && !r_wdata[0] && (r_addr[IDX_W-1:0] == IDX_W'(i));
        assign rr = r_sel && r_wr &&  r_wdata[0] && (r_addr[IDX_W-1:0] == IDX_W'(i));

        // tie on a free latch goes left, R5
        assert_tie_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (lq && rq && !own_l[i] && !own_r[i]) |=> (own_l[i] && pend_r[i]));

        // pending request is served on release, R4
        assert_pass_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && pend_r[i] && lr) |=> (own_r[i] && !pend_r[i]));

        // release by a non-owner changes nothing for it, R7
        assert_nonowner_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_r[i] && !pend_r[i] && rr) |=> !own_r[i]);

        // ownership only starts from a request or a pending mark, R2
        assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_r[i] && !rq && !pend_r[i]) |=> !own_r[i]);
    end

endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
    .own_l(own_l), .own_r(own_r), .pend_r(pend_r)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;

    localparam int NUM_SEM = 8;
    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 16;

    // bench op codes
    localparam int OP_IDLE = 0, OP_REQ = 1, OP_REL = 2, OP_RD = 3, OP_NOSEL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel, l_wr, l_oe, r_sel, r_wr, r_oe;
    logic [ADDR_W-1:0] l_addr, r_addr;
    logic [DATA_W-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    always #4 clk = ~clk;

    sem_bank #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model: 0 free, 1 left, 2 right
    int m_st [NUM_SEM];
    bit m_pl [NUM_SEM];
    bit m_pr [NUM_SEM];

    function automatic logic [DATA_W-1:0] exp_rd(int op, int idx, bit left);
        if (op != OP_RD) return '1;
        if (m_st[idx] == (left ? 1 : 2)) return '0;
        return '1;
    endfunction

    task automatic check(bit ok, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(int lop, int li, int rop, int ri);
        for (int i = 0; i < NUM_SEM; i++) begin
            bit ql, qr, sl, sr;
            ql = (lop == OP_REQ) && (li == i);
            sl = (lop == OP_REL) && (li == i);
            qr = (rop == OP_REQ) && (ri == i);
            sr = (rop == OP_REL) && (ri == i);
            case (m_st[i])
                0: begin
                    if (ql) begin m_st[i] = 1; m_pr[i] = qr; end
                    else if (qr) m_st[i] = 2;
                end
                1: begin
                    if (sl) begin
                        if (m_pr[i] || qr) begin m_st[i] = 2; m_pr[i] = 1'b0; end
                        else m_st[i] = 0;
                    end else if (qr) m_pr[i] = 1'b1;
                end
                default: begin
                    if (sr) begin
                        if (m_pl[i] || ql) begin m_st[i] = 1; m_pl[i] = 1'b0; end
                        else m_st[i] = 0;
                    end else if (ql) m_pl[i] = 1'b1;
                end
            endcase
        end
    endtask

    task automatic set_port(int op, logic [ADDR_W-1:0] a, output logic sel, output logic wr,
                            output logic oe, output logic [ADDR_W-1:0] addr,
                            output logic [DATA_W-1:0] wd);
        sel  = (op == OP_REQ) || (op == OP_REL) || (op == OP_RD);
        wr   = (op == OP_REQ) || (op == OP_REL) || (op == OP_NOSEL);
        oe   = (op == OP_RD);
        addr = a;
        wd   = DATA_W'($urandom) & ~DATA_W'(1);
        if (op == OP_REL) wd[0] = 1'b1;
        if (op == OP_NOSEL) wd[0] = $urandom_range(0, 1) != 0;
    endtask

    // one cycle: drive after the falling edge, compare, then advance the model
    task automatic cyc(int lop, logic [ADDR_W-1:0] la, int rop, logic [ADDR_W-1:0] ra, string tag);
        int li, ri;
        logic [DATA_W-1:0] el, er;
        @(negedge clk);
        set_port(lop, la, l_sel, l_wr, l_oe, l_addr, l_wdata);
        set_port(rop, ra, r_sel, r_wr, r_oe, r_addr, r_wdata);
        li = int'(la[2:0]);
        ri = int'(ra[2:0]);
        #1;
        el = exp_rd(lop, li, 1'b1);
        er = exp_rd(rop, ri, 1'b0);
        if (lop == OP_RD || rop == OP_RD) begin
            check(l_rdata == el, tag, l_rdata, el);
            check(r_rdata == er, tag, r_rdata, er);
        end
        model_step(lop, li, rop, ri);
    endtask

    function automatic logic [ADDR_W-1:0] ad(int idx);
        return ADDR_W'(idx);
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < NUM_SEM; i++) begin m_st[i] = 0; m_pl[i] = 0; m_pr[i] = 0; end
        l_sel = 0; l_wr = 0; l_oe = 0; l_addr = '0; l_wdata = '0;
        r_sel = 0; r_wr = 0; r_oe = 0; r_addr = '0; r_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: every latch free after reset
        for (int i = 0; i < NUM_SEM; i++) cyc(OP_RD, ad(i), OP_RD, ad(i), "R9");
        // R8: idle ports read all ones
        @(negedge clk);
        l_sel = 0; r_sel = 0; l_oe = 1; r_oe = 1;
        #1;
        check(l_rdata == '1, "R8 idle", l_rdata, '1);
        check(r_rdata == '1, "R8 idle", r_rdata, '1);

        // R2 grant, R10 re-request by owner
        cyc(OP_REQ, ad(3), OP_IDLE, ad(0), "R2");
        cyc(OP_RD, ad(3), OP_RD, ad(3), "R2");
        cyc(OP_REQ, ad(3), OP_IDLE, ad(0), "R10");
        cyc(OP_RD, ad(3), OP_RD, ad(3), "R10");
        // R3 blocked request goes pending, R7 pending port release ignored
        cyc(OP_IDLE, ad(0), OP_REQ, ad(3), "R3");
        cyc(OP_RD, ad(3), OP_RD, ad(3), "R3");
        cyc(OP_IDLE, ad(0), OP_REL, ad(3), "R7");
        cyc(OP_RD, ad(3), OP_RD, ad(3), "R7");
        // R4 hand-over at release
        cyc(OP_REL, ad(3), OP_IDLE, ad(0), "R4");
        cyc(OP_RD, ad(3), OP_RD, ad(3), "R4");
        // R6 owner release frees the latch
        cyc(OP_IDLE, ad(0), OP_REL, ad(3), "R6");
        cyc(OP_RD, ad(3), OP_RD, ad(3), "R6");
        // R5 tie on a free latch
        cyc(OP_REQ, ad(6), OP_REQ, ad(6), "R5");
        cyc(OP_RD, ad(6), OP_RD, ad(6), "R5");
        cyc(OP_REL, ad(6), OP_RD, ad(6), "R5");
        cyc(OP_RD, ad(6), OP_RD, ad(6), "R5");
        // R1 upper address bits ignored
        cyc(OP_REQ, ADDR_W'(14'h3FF1), OP_IDLE, ad(0), "R1");
        cyc(OP_RD, ADDR_W'(14'h2001), OP_RD, ADDR_W'(14'h1FF9), "R1");
        // R10 unselected writes ignored
        cyc(OP_NOSEL, ad(2), OP_NOSEL, ad(1), "R10");
        cyc(OP_RD, ad(2), OP_RD, ad(1), "R10");
        cyc(OP_NOSEL, ad(1), OP_NOSEL, ad(2), "R10");
        cyc(OP_RD, ad(1), OP_RD, ad(2), "R10");

        // random traffic, R8 reads checked against the model
        for (int n = 0; n < 4000; n++) begin
            int lop, rop;
            lop = $urandom_range(0, 4);
            rop = $urandom_range(0, 4);
            cyc(lop, ADDR_W'($urandom), rop, ADDR_W'($urandom), "R8 random");
        end
        for (int i = 0; i < NUM_SEM; i++) cyc(OP_RD, ad(i), OP_RD, ad(i), "R3 final");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule